// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds a parameterised bank of 32-bit event counters. Each counter has a 10-bit selector that decides what it counts. It can count processor cycle pulses, retired-instruction pulses, or increments requested by software through a register write. A counter that wraps from all ones to zero records the wrap in an overflow status register, at the bit matching its index. Bit 31 of that status register is reserved for a cycle counter that sits outside the block; that counter reports its own overflow through a pulse input.

Software sets up the bank through a simple one-cycle write port. A combinational read port returns the stored state. The counter-enable, overflow-status and interrupt-enable registers each have one write address that sets bits and another that clears bits, so no read-modify-write is needed. A single level interrupt is formed from three things: the global enable, the interrupt enables and the overflow status. The interrupt follows every change to any of them.

Addresses are `{kind[3:0], index[4:0]}`. The kinds are 0 control, 1 enable-set, 2 enable-clear, 3 overflow-set, 4 overflow-clear, 5 irq-enable-set, 6 irq-enable-clear, 7 software increment, 8 event type of counter `index`, and 9 count of counter `index`. Reading a set or clear address returns the register it acts on.

Top module: `ecb_bank`

## Requirements
- R1: After a synchronous active-low reset, every count, event type, counter enable, overflow bit, interrupt enable and the global enable read as zero, and `irq` is low.
- R2: A counter whose type is 0x011 adds one for each cycle-event pulse, and a counter whose type is 0x008 adds one for each instruction pulse. It does so only while control bit 0 is set and the counter's enable bit is set.
- R3: A counter whose type is any code other than 0x000, 0x008 or 0x011 never changes, except by a direct count write.
- R4: A write to the software-increment address adds one to each counter that meets three conditions: its bit in the written data is set, it is enabled, and its type is 0x000. Counters of other types are unaffected.
- R5: An increment from 0xFFFFFFFF leaves the count at 0 and sets overflow bit i for counter i. Loading a value through a count write never sets an overflow bit.
- R6: A set address ORs the written data into its register. A clear address removes the written ones from its register. Both are limited to bits 0..N-1 and bit 31, so every other bit stays zero.
- R7: A pulse on `cyc_ovf` sets overflow bit 31.
- R8: `irq` equals control bit 0 AND the OR of (interrupt enable AND overflow status). It reflects a register write from the cycle after that write.
- R9: When hardware sets an overflow bit in the same cycle that software clears it, the bit ends up set.
- R10: Reading the control address returns N in bits 15:11 and the global enable in bit 0. An event type reads back only its low 10 bits.
- R11: A count write loads the written value and takes priority over any increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 9 | Write address {kind, index} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 9 | Read address {kind, index} |
| rd_data | output | 32 | Combinational read data |
| evt_cycle | input | 1 | Cycle event pulse |
| evt_instr | input | 1 | Instruction-retired event pulse |
| cyc_ovf | input | 1 | Overflow pulse from the external cycle counter |
| irq | output | 1 | Level interrupt |

## Verification
Every write, event pulse and overflow is captured at the same rising edge. Its effect on counts and status shows on the read port just after that edge. `irq` is decoded from registers, so it follows one edge after the write or wrap that changes its inputs. The bench drives inputs on the falling edge and applies the same step to its own model. It then reads every count, the status registers and `irq` between 1 ns and 2 ns after the next rising edge, before the next falling edge. Directed steps cover a wrap that collides with an overflow clear, and a count load in the same cycle as an increment.

// File: rtl/ecb_pkg.sv
`timescale 1ns/1ps
// ecb_pkg: shared constants and the register-kind encoding for the event
// counter bank. Assumes a 9-bit address of {kind[3:0], index[4:0]}.
package ecb_pkg;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 10;
    localparam int KIND_W = 4;
    localparam int IDX_W  = 5;
    localparam int ADDR_W = KIND_W + IDX_W;

    localparam logic [SEL_W-1:0] SEL_SWINC  = 10'h000;
    localparam logic [SEL_W-1:0] SEL_INSTR  = 10'h008;
    localparam logic [SEL_W-1:0] SEL_CYCLES = 10'h011;

    typedef enum logic [KIND_W-1:0] {
        K_CTRL      = 4'd0,
        K_EN_SET    = 4'd1,
        K_EN_CLR    = 4'd2,
        K_OVF_SET   = 4'd3,
        K_OVF_CLR   = 4'd4,
        K_IEN_SET   = 4'd5,
        K_IEN_CLR   = 4'd6,
        K_SWINC     = 4'd7,
        K_TYPE      = 4'd8,
        K_COUNT     = 4'd9
    } reg_kind_e;
endpackage

// File: rtl/ecb_flag_reg.sv
`timescale 1ns/1ps
// ecb_flag_reg: 32-bit register with write-one-to-set and write-one-to-clear
// strobes plus a hardware set vector. Only bits in MASK can ever be one.
// Assumes set and clear strobes are one-cycle; the hardware set beats a clear.
module ecb_flag_reg #(
    parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [31:0] wdata,
    input  logic [31:0] hw_set,
    output logic [31:0] q
);
    logic [31:0] set_vec, clr_vec, hw_vec;

    // Form the masked set, clear and hardware vectors.
    always_comb begin
        set_vec = set_we ? (wdata & MASK) : '0;
        clr_vec = clr_we ? (wdata & MASK) : '0;
        hw_vec  = hw_set & MASK;
    end

    // Update the flags; hardware set is applied last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q | set_vec) & ~clr_vec) | hw_vec;
    end

    // R9: a hardware set is always visible after the edge.
    p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_vec != '0) |=> ((q & $past(hw_vec)) == $past(hw_vec)));
    // R6: unimplemented bits never become one.
    p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & ~MASK) == '0));
endmodule

// File: rtl/ecb_counter.sv
`timescale 1ns/1ps
// ecb_counter: one 32-bit event counter. Picks its event from the selector,
// adds one when active, loads on a direct write (which wins), and reports a
// wrap pulse when bit 31 falls because of an increment.
module ecb_counter
    import ecb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    input  logic             evt_cycle,
    input  logic             evt_instr,
    input  logic             sw_hit,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    output logic [W-1:0]     count,
    output logic             wrap
);
    logic         incr;
    logic [W-1:0] next_cnt;

    // Decide whether the selected event fires this cycle.
    always_comb begin
        incr = active & (((sel == SEL_CYCLES) & evt_cycle)
                       | ((sel == SEL_INSTR)  & evt_instr)
                       | ((sel == SEL_SWINC)  & sw_hit));
        next_cnt = count + 1'b1;
        wrap = incr & ~load & count[W-1] & ~next_cnt[W-1];
    end

    // Hold, load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (incr) count <= next_cnt;
    end

    // R2: an increment below the top advances by one.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (incr && !load && count != '1) |=> (count == $past(count) + 1'b1));
    // R5: the top value wraps to zero.
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (incr && !load && count == '1) |=> (count == '0));
    // R3: no event and no load keeps the count.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!incr && !load) |=> $stable(count));
    // R11: a load always wins.
    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/ecb_bank.sv
`timescale 1ns/1ps
// ecb_bank: N event counters (N at most 31) with enable, overflow status and
// interrupt-enable flag registers, a software increment, and a level interrupt.
// Assumes single-cycle writes; reads are combinational from stored state.
module ecb_bank
    import ecb_pkg::*;
#(
    parameter int N = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              evt_cycle,
    input  logic              evt_instr,
    input  logic              cyc_ovf,
    output logic              irq
);
    localparam logic [31:0] IMPL = 32'((64'd1 << N) - 64'd1) | 32'h8000_0000;
    localparam logic [IDX_W-1:0] N_FIELD = IDX_W'(N);

    reg_kind_e         wr_kind, rd_kind;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic              ctrl_en;
    logic [31:0]       cnten, ovf, inten, ovf_hw;
    logic [N-1:0]      wraps;
    logic [DATA_W-1:0] cnt   [N];
    logic [SEL_W-1:0]  etype [N];

    // Split the addresses into kind and index.
    always_comb begin
        wr_kind = reg_kind_e'(wr_addr[ADDR_W-1 -: KIND_W]);
        wr_idx  = wr_addr[IDX_W-1:0];
        rd_kind = reg_kind_e'(rd_addr[ADDR_W-1 -: KIND_W]);
        rd_idx  = rd_addr[IDX_W-1:0];
    end

    // Global enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_en <= 1'b0;
        else if (wr_en && wr_kind == K_CTRL)  ctrl_en <= wr_data[0];
    end

    // Collect hardware overflow sets: counter wraps and the cycle counter.
    always_comb begin
        ovf_hw = '0;
        ovf_hw[N-1:0] = wraps;
        ovf_hw[31] = cyc_ovf;
    end

    ecb_flag_reg #(.MASK(IMPL)) u_cnten (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_en && wr_kind == K_EN_SET),
        .clr_we(wr_en && wr_kind == K_EN_CLR),
        .wdata(wr_data), .hw_set(32'd0), .q(cnten));

    ecb_flag_reg #(.MASK(IMPL)) u_ovf (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_en && wr_kind == K_OVF_SET),
        .clr_we(wr_en && wr_kind == K_OVF_CLR),
        .wdata(wr_data), .hw_set(ovf_hw), .q(ovf));

    ecb_flag_reg #(.MASK(IMPL)) u_inten (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_en && wr_kind == K_IEN_SET),
        .clr_we(wr_en && wr_kind == K_IEN_CLR),
        .wdata(wr_data), .hw_set(32'd0), .q(inten));

    for (genvar i = 0; i < N; i++) begin : g_ctr
        logic sel_me;
        // Decode whether this write targets counter i.
        always_comb sel_me = wr_en && (wr_idx == IDX_W'(i));

        // Event type register, low 10 bits kept.
        always_ff @(posedge clk) begin
            if (!rst_n)                            etype[i] <= '0;
            else if (sel_me && wr_kind == K_TYPE)  etype[i] <= wr_data[SEL_W-1:0];
        end

        ecb_counter u_cnt (
            .clk(clk), .rst_n(rst_n),
            .active(ctrl_en & cnten[i]),
            .sel(etype[i]),
            .evt_cycle(evt_cycle), .evt_instr(evt_instr),
            .sw_hit(wr_en && wr_kind == K_SWINC && wr_data[i]),
            .load(sel_me && wr_kind == K_COUNT),
            .load_val(wr_data),
            .count(cnt[i]), .wrap(wraps[i]));
    end

    // Level interrupt from the stored enable, interrupt-enable and status.
    always_comb irq = ctrl_en & |(inten & ovf);

    // Read multiplexer over the stored state.
    always_comb begin
        rd_data = '0;
        unique case (rd_kind)
            K_CTRL:               rd_data = {16'd0, N_FIELD, 10'd0, ctrl_en};
            K_EN_SET, K_EN_CLR:   rd_data = cnten;
            K_OVF_SET, K_OVF_CLR: rd_data = ovf;
            K_IEN_SET, K_IEN_CLR: rd_data = inten;
            K_TYPE, K_COUNT: begin
                for (int i = 0; i < N; i++) begin
                    if (rd_idx == IDX_W'(i))
                        rd_data = (rd_kind == K_TYPE) ? {22'd0, etype[i]} : cnt[i];
                end
            end
            default:              rd_data = '0;
        endcase
    end

    // R8: the interrupt is never raised with the global enable off.
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_en);
    // R7: a cycle-counter overflow pulse lands in bit 31.
    p_cyc_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_ovf |=> ovf[31]);
endmodule

// File: tb/ecb_bank_tb_top.sv
`timescale 1ns/1ps
module ecb_bank_tb_top;
    import ecb_pkg::*;
    localparam int N = 6;
    localparam logic [31:0] MASK = 32'((64'd1 << N) - 64'd1) | 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic evt_cycle = 1'b0, evt_instr = 1'b0, cyc_ovf = 1'b0;
    logic irq;

    int checks = 0;
    int errors = 0;

    logic        m_en;
    logic [31:0] m_cnten, m_ovf, m_inten;
    logic [31:0] m_cnt [N];
    logic [9:0]  m_type [N];

    always #2.5 clk = ~clk;

    ecb_bank #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_cycle(evt_cycle), .evt_instr(evt_instr), .cyc_ovf(cyc_ovf),
        .irq(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] flag_upd(logic [31:0] q, logic s, logic c,
                                            logic [31:0] d, logic [31:0] hw);
        logic [31:0] r;
        r = q;
        if (s) r = r | (d & MASK);
        if (c) r = r & ~(d & MASK);
        return r | (hw & MASK);
    endfunction

    task automatic rd(input logic [3:0] kind, input int idx, output logic [31:0] v);
        rd_addr = {kind, 5'(idx)};
        #0.1;
        v = rd_data;
    endtask

    task automatic compare_all(input string req);
        logic [31:0] v;
        check({req, " irq R8"}, {31'd0, irq},
              {31'd0, m_en & (|(m_inten & m_ovf))});
        for (int i = 0; i < N; i++) begin
            rd(4'd9, i, v); check({req, " count"}, v, m_cnt[i]);
        end
        rd(4'd3, 0, v); check({req, " status R5"}, v, m_ovf);
        rd(4'd1, 0, v); check({req, " enables R6"}, v, m_cnten);
        rd(4'd5, 0, v); check({req, " irq-en R6"}, v, m_inten);
    endtask

    // One clock step: drive at the falling edge, update the model, sample after the rise.
    task automatic step(input logic we, input logic [3:0] kind, input int idx,
                        input logic [31:0] d, input logic ec, input logic ei,
                        input logic co, input string req);
        logic [31:0] hw;
        @(negedge clk);
        wr_en = we; wr_addr = {kind, 5'(idx)}; wr_data = d;
        evt_cycle = ec; evt_instr = ei; cyc_ovf = co;
        hw = '0;
        hw[31] = co;
        for (int i = 0; i < N; i++) begin
            logic inc;
            inc = m_en && m_cnten[i] &&
                  ((m_type[i] == 10'h011 && ec) || (m_type[i] == 10'h008 && ei) ||
                   (m_type[i] == 10'h000 && we && kind == 4'd7 && d[i]));
            if (we && kind == 4'd9 && idx == i) m_cnt[i] = d;
            else if (inc) begin
                if (m_cnt[i] == 32'hFFFF_FFFF) hw[i] = 1'b1;
                m_cnt[i] = m_cnt[i] + 1;
            end
            if (we && kind == 4'd8 && idx == i) m_type[i] = d[9:0];
        end
        m_cnten = flag_upd(m_cnten, we && kind == 4'd1, we && kind == 4'd2, d, '0);
        m_ovf   = flag_upd(m_ovf,   we && kind == 4'd3, we && kind == 4'd4, d, hw);
        m_inten = flag_upd(m_inten, we && kind == 4'd5, we && kind == 4'd6, d, '0);
        if (we && kind == 4'd0) m_en = d[0];
        @(posedge clk);
        #1;
        wr_en = 1'b0; evt_cycle = 1'b0; evt_instr = 1'b0; cyc_ovf = 1'b0;
        compare_all(req);
    endtask

    initial begin : watchdog
        #900000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int seed;
        seed = $urandom(32'd1234);
        m_en = 0; m_cnten = 0; m_ovf = 0; m_inten = 0;
        for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_type[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1 reset");
        check("R1 irq low", {31'd0, irq}, 32'd0);
        rd(4'd8, 2, v); check("R1 type zero", v, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R10: control read reports N and the enable.
        step(1, 4'd0, 0, 32'h1, 0, 0, 0, "R10");
        rd(4'd0, 0, v); check("R10 ctrl", v, (32'(N) << 11) | 32'h1);
        step(1, 4'd8, 1, 32'hFFFF_F411, 0, 0, 0, "R10");
        rd(4'd8, 1, v); check("R10 type low bits", v, 32'h011);

        // R2: cycle and instruction counting.
        step(1, 4'd8, 0, 32'h011, 0, 0, 0, "R2");
        step(1, 4'd8, 2, 32'h008, 0, 0, 0, "R2");
        step(1, 4'd1, 0, 32'h7, 0, 0, 0, "R2");
        step(0, 4'd0, 0, 0, 1, 1, 0, "R2 both events");
        step(0, 4'd0, 0, 0, 1, 0, 0, "R2 cycle only");

        // R3: unsupported code never counts.
        step(1, 4'd8, 3, 32'h005, 0, 0, 0, "R3");
        step(1, 4'd1, 0, 32'h8, 0, 0, 0, "R3");
        step(0, 4'd0, 0, 0, 1, 1, 0, "R3 events");
        step(1, 4'd7, 0, 32'h3F, 0, 0, 0, "R3 R4 swinc");
        rd(4'd9, 3, v); check("R3 unchanged", v, 32'd0);

        // R4 + R5: software increment wraps counter 4.
        step(1, 4'd1, 0, 32'h10, 0, 0, 0, "R4");
        step(1, 4'd9, 4, 32'hFFFF_FFFF, 0, 0, 0, "R5 load no ovf");
        rd(4'd3, 0, v); check("R5 load sets nothing", v, 32'd0);
        step(1, 4'd7, 0, 32'h10, 0, 0, 0, "R4 R5 wrap");
        rd(4'd3, 0, v); check("R5 bit4", v, 32'h10);

        // R8: interrupt follows enables.
        step(1, 4'd5, 0, 32'h10, 0, 0, 0, "R8");
        check("R8 irq high", {31'd0, irq}, 32'd1);
        step(1, 4'd0, 0, 32'h0, 0, 0, 0, "R8 global off");
        check("R8 irq low", {31'd0, irq}, 32'd0);
        step(1, 4'd0, 0, 32'h1, 0, 0, 0, "R8");

        // R7 + R6: cycle counter overflow and masked set.
        step(0, 4'd0, 0, 0, 0, 0, 1, "R7");
        rd(4'd3, 0, v); check("R7 bit31", v, 32'h8000_0010);
        step(1, 4'd3, 0, 32'hFFFF_FFFF, 0, 0, 0, "R6 mask");
        rd(4'd3, 0, v); check("R6 masked set", v, MASK);
        step(1, 4'd4, 0, 32'hFFFF_FFFF, 0, 0, 0, "R6 clear");

        // R9: wrap of counter 0 against a clear of bit 0.
        step(1, 4'd9, 0, 32'hFFFF_FFFF, 0, 0, 0, "R9");
        step(1, 4'd4, 0, 32'h1, 1, 0, 0, "R9 collide");
        rd(4'd3, 0, v); check("R9 set wins", v & 32'h1, 32'h1);

        // R11: load beats an increment in the same cycle.
        @(negedge clk);
        step(1, 4'd9, 0, 32'h1234, 1, 0, 0, "R11");
        rd(4'd9, 0, v); check("R11 load wins", v, 32'h1234);

        // Random mix.
        for (int n = 0; n < 3000; n++) begin
            int k, idx;
            logic [31:0] d;
            k = $urandom_range(0, 12);
            idx = $urandom_range(0, N - 1);
            d = $urandom;
            if (k == 8) d = (d[1:0] == 0) ? 32'h0 : (d[1:0] == 1) ? 32'h8 :
                            (d[1:0] == 2) ? 32'h11 : d;
            if (k == 9) d = 32'hFFFF_FFF0 | (d & 32'hF);
            if (k == 0) d = {31'd0, ($urandom_range(0, 7) != 0)};
            step(k <= 9, 4'(k), idx, d, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 19) == 0, "R2 R4 R5 R6 random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule